// File: doc/BRIEF.md
# Pausable Multi-Step Divider

This block divides a dividend by a 16-bit divisor over a fixed sequence of 19 steps. It returns a 16-bit quotient and a 16-bit remainder. Three mode inputs pick the operation:
- a 16-bit or a 32-bit dividend;
- unsigned or two's-complement operands;
- integer or fractional (1.15) interpretation.

A start strobe captures the operands and the mode. After that, each clock cycle with the step enable high runs one step. A host that must service an interrupt drops the step enable for as long as it needs, and the operation resumes later from exactly where it stopped.

The step schedule is fixed:

| Step | Action |
|------|--------|
| 0 | Forms the operand magnitudes and aligns the working dividend |
| 1 to 16 | One restoring quotient bit each |
| 17 | Applies the result signs |
| 18 | Publishes quotient, remainder and the divide-by-zero flag |

A one-cycle done pulse then marks completion. The published results stay on the outputs until the next operation completes.

Top module: `iter_divider`

## Requirements
- R1: With wide=0, frac=0 and signed_op=0, the result is quotient = floor(A/B) and remainder = A mod B. A is dividend[15:0] and B is divisor, both unsigned.
- R2: With wide=1 and frac=0, the full 32-bit dividend is used. This mode requires the true quotient to fit in 16 bits, which means the magnitude of dividend[31:16] must be less than the divisor magnitude.
- R3: With signed_op=1, operands are two's complement. The quotient is truncated toward zero, and the remainder is negated when the dividend is negative.
- R4: With frac=1, A = dividend[15:0] and wide is ignored. The quotient magnitude is floor(|A|*2^15/|B|) and the remainder magnitude is (|A|*2^15) mod |B|. Signs follow the rules of R3. This mode requires |A| < |B|.
- R5: With step_en held high, done is high for exactly one cycle. That cycle follows the 19th clock edge after the edge that accepts start. busy is high from the cycle after start until done.
- R6: While busy with step_en low, the operation makes no progress. Completion is delayed by exactly the number of such cycles, and the results equal those of an uninterrupted run.
- R7: A start strobe while busy is ignored. Timing and results remain those of the operation in flight.
- R8: div_zero is updated together with the results. It is 1 when the divisor was zero, in which case the 19 steps still complete; otherwise it is 0. Quotient and remainder are unspecified after a zero divisor.
- R9: After reset, busy, done, div_zero, quotient and remainder are all 0.
- R10: quotient, remainder and div_zero change only on the edge that raises done. They hold their values until the next completion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Starts an operation when idle |
| step_en | input | 1 | Runs one step per cycle while high |
| dividend | input | 32 | Dividend; the low half only in 16-bit and fractional modes |
| divisor | input | 16 | Divisor |
| wide | input | 1 | 1 selects a 32-bit dividend |
| signed_op | input | 1 | 1 selects two's-complement operands |
| frac | input | 1 | 1 selects 1.15 fractional division |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | 16 | Published quotient |
| remainder | output | 16 | Published remainder |
| div_zero | output | 1 | Last operation had a zero divisor |

## Verification
The directed cases cover these corners:
- **Sign combinations.** Negative dividends, negative divisors and both together. A design that copied the divisor's sign into the remainder, or that rounded the quotient away from zero, gives wrong values here.
- **Interrupted runs.** step_en is pulled low at several points, including the very first and the last step. A design that advanced its counter or shifted its partial remainder while paused would finish early or return corrupted bits.
- **Late second start.** A start arriving mid-operation must not restart or retarget the operation in flight.
- **Zero divisor.** The operation must still take its full 19 steps and raise the flag.
- **Result hold.** Outputs are compared before and after done. This catches results that leak out during the sequence or are cleared after the pulse.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef struct packed {
    logic wide;
    logic sgn;
    logic frac;
  } div_mode_t;
endpackage

// File: rtl/div_seq.sv
module div_seq #(
  parameter int NSTEP = 19,
  localparam int CW = $clog2(NSTEP)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          step_en,
  output logic          busy,
  output logic          done,
  output logic [CW-1:0] cnt,
  output logic          go
);
  localparam logic [CW-1:0] LAST = CW'(NSTEP - 1);

  assign go = busy && step_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      done <= 1'b0;
      cnt  <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1;
          cnt  <= '0;
        end
      end else if (step_en) begin
        if (cnt == LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
          cnt  <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_done_on_finish_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);
  assert_pause_freeze_R6: assert property (@(posedge clk) disable iff (rst)
    (busy && !step_en) |=> (busy && $stable(cnt)));
  assert_start_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && start && step_en && cnt != LAST) |=> (busy && cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/div_prep.sv
module div_prep
  import div_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [2*W-1:0] dvd,
  input  logic [W-1:0]   dvs,
  input  div_mode_t      mode,
  output logic [2*W-1:0] mag_dvd,
  output logic [W-1:0]   mag_dvs,
  output logic           neg_q,
  output logic           neg_r
);
  logic [W-1:0]   lo;
  logic [W-1:0]   lo_mag;
  logic [2*W-1:0] full_mag;
  logic           dvd_neg;
  logic           dvs_neg;

  always_comb begin
    lo       = dvd[W-1:0];
    lo_mag   = (mode.sgn && lo[W-1]) ? (~lo + 1'b1) : lo;
    full_mag = (mode.sgn && dvd[2*W-1]) ? (~dvd + 1'b1) : dvd;
    dvs_neg  = mode.sgn && dvs[W-1];
    mag_dvs  = dvs_neg ? (~dvs + 1'b1) : dvs;
    if (mode.frac) begin
      dvd_neg = mode.sgn && lo[W-1];
      mag_dvd = {1'b0, lo_mag, {(W-1){1'b0}}};
    end else if (mode.wide) begin
      dvd_neg = mode.sgn && dvd[2*W-1];
      mag_dvd = full_mag;
    end else begin
      dvd_neg = mode.sgn && lo[W-1];
      mag_dvd = {{W{1'b0}}, lo_mag};
    end
    neg_r = dvd_neg;
    neg_q = dvd_neg ^ dvs_neg;
  end
endmodule

// File: rtl/div_core.sv
module div_core #(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic           iter,
  input  logic [2*W-1:0] mag_dvd,
  input  logic [W-1:0]   mag_dvs,
  output logic [W-1:0]   rem,
  output logic [W-1:0]   quo
);
  logic [W-1:0] dsr;
  logic [W:0]   shifted;
  logic [W:0]   diff;
  logic         qbit;

  always_comb begin
    shifted = {rem, quo[W-1]};
    diff    = shifted - {1'b0, dsr};
    qbit    = (shifted >= {1'b0, dsr});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem <= '0;
      quo <= '0;
      dsr <= '0;
    end else if (load) begin
      rem <= mag_dvd[2*W-1:W];
      quo <= mag_dvd[W-1:0];
      dsr <= mag_dvs;
    end else if (iter) begin
      rem <= qbit ? diff[W-1:0] : shifted[W-1:0];
      quo <= {quo[W-2:0], qbit};
    end
  end

  assert_core_idle_R6: assert property (@(posedge clk) disable iff (rst)
    (!load && !iter) |=> ($stable(rem) && $stable(quo) && $stable(dsr)));
endmodule

// File: rtl/div_fix.sv
module div_fix #(
  parameter int W = 16
) (
  input  logic [W-1:0] rem,
  input  logic [W-1:0] quo,
  input  logic         neg_q,
  input  logic         neg_r,
  output logic [W-1:0] q_out,
  output logic [W-1:0] r_out
);
  assign q_out = neg_q ? (~quo + 1'b1) : quo;
  assign r_out = neg_r ? (~rem + 1'b1) : rem;
endmodule

// File: rtl/iter_divider.sv
module iter_divider
  import div_pkg::*;
#(
  parameter int W = 16,
  localparam int NSTEP = W + 3,
  localparam int CW = $clog2(NSTEP)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic           step_en,
  input  logic [2*W-1:0] dividend,
  input  logic [W-1:0]   divisor,
  input  logic           wide,
  input  logic           signed_op,
  input  logic           frac,
  output logic           busy,
  output logic           done,
  output logic [W-1:0]   quotient,
  output logic [W-1:0]   remainder,
  output logic           div_zero
);
  localparam logic [CW-1:0] FIX_STEP = CW'(W + 1);
  localparam logic [CW-1:0] PUB_STEP = CW'(W + 2);

  logic [2*W-1:0] op_dvd;
  logic [W-1:0]   op_dvs;
  div_mode_t      op_mode;
  logic [CW-1:0]  cnt;
  logic           go;
  logic           do_load, do_iter, do_fix, do_pub;
  logic [2*W-1:0] mag_dvd;
  logic [W-1:0]   mag_dvs;
  logic           neg_q, neg_r;
  logic [W-1:0]   core_rem, core_quo;
  logic [W-1:0]   fix_q, fix_r;
  logic [W-1:0]   res_q, res_r;

  div_seq #(.NSTEP(NSTEP)) u_seq (
    .clk(clk), .rst(rst), .start(start), .step_en(step_en),
    .busy(busy), .done(done), .cnt(cnt), .go(go)
  );

  assign do_load = go && (cnt == '0);
  assign do_iter = go && (cnt != '0) && (cnt < FIX_STEP);
  assign do_fix  = go && (cnt == FIX_STEP);
  assign do_pub  = go && (cnt == PUB_STEP);

  always_ff @(posedge clk) begin
    if (rst) begin
      op_dvd  <= '0;
      op_dvs  <= '0;
      op_mode <= '0;
    end else if (start && !busy) begin
      op_dvd  <= dividend;
      op_dvs  <= divisor;
      op_mode <= '{wide: wide, sgn: signed_op, frac: frac};
    end
  end

  div_prep #(.W(W)) u_prep (
    .dvd(op_dvd), .dvs(op_dvs), .mode(op_mode),
    .mag_dvd(mag_dvd), .mag_dvs(mag_dvs), .neg_q(neg_q), .neg_r(neg_r)
  );

  div_core #(.W(W)) u_core (
    .clk(clk), .rst(rst), .load(do_load), .iter(do_iter),
    .mag_dvd(mag_dvd), .mag_dvs(mag_dvs), .rem(core_rem), .quo(core_quo)
  );

  div_fix #(.W(W)) u_fix (
    .rem(core_rem), .quo(core_quo), .neg_q(neg_q), .neg_r(neg_r),
    .q_out(fix_q), .r_out(fix_r)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q     <= '0;
      res_r     <= '0;
      quotient  <= '0;
      remainder <= '0;
      div_zero  <= 1'b0;
    end else begin
      if (do_fix) begin
        res_q <= fix_q;
        res_r <= fix_r;
      end
      if (do_pub) begin
        quotient  <= res_q;
        remainder <= res_r;
        div_zero  <= (op_dvs == '0);
      end
    end
  end

  assert_hold_outputs_R10: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(quotient) && $stable(remainder) && $stable(div_zero)));
  assert_zero_flag_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> (div_zero == (op_dvs == '0)));
  assert_pause_state_R6: assert property (@(posedge clk) disable iff (rst)
    (busy && !step_en) |=> ($stable(core_rem) && $stable(core_quo) && $stable(res_q)));
  assert_idle_done_R5: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

// File: tb/sim_iter_divider.sv
`timescale 1ns/1ps
module sim_iter_divider;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        step_en = 1'b0;
  logic [31:0] dividend = '0;
  logic [15:0] divisor = '0;
  logic        wide = 1'b0, signed_op = 1'b0, frac = 1'b0;
  logic        busy, done, div_zero;
  logic [15:0] quotient, remainder;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  iter_divider u0 (
    .clk(clk), .rst(rst), .start(start), .step_en(step_en),
    .dividend(dividend), .divisor(divisor), .wide(wide),
    .signed_op(signed_op), .frac(frac), .busy(busy), .done(done),
    .quotient(quotient), .remainder(remainder), .div_zero(div_zero)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic void model(input logic [31:0] dvd, input logic [15:0] dvs,
                                input logic w, input logic s, input logic f,
                                output logic [15:0] q, output logic [15:0] r);
    longint a, b, ma, mb, qm, rm;
    if (w && !f) a = s ? longint'($signed(dvd)) : longint'(dvd);
    else         a = s ? longint'($signed(dvd[15:0])) : longint'(dvd[15:0]);
    b  = s ? longint'($signed(dvs)) : longint'(dvs);
    ma = (a < 0) ? -a : a;
    mb = (b < 0) ? -b : b;
    if (f) ma = ma * 32768;
    qm = ma / mb;
    rm = ma % mb;
    if ((a < 0) != (b < 0)) qm = -qm;
    if (a < 0) rm = -rm;
    q = qm[15:0];
    r = rm[15:0];
  endfunction

  // One operation: pause_mask bit n drops step_en before edge n+1 after start;
  // inject_at >= 0 raises start again at that edge count.
  task automatic run_div(input string tag, input logic [31:0] dvd, input logic [15:0] dvs,
                         input logic w, input logic s, input logic f,
                         input logic [31:0] pause_mask, input int inject_at);
    logic [15:0] eq, er, pq, pr;
    int edges, en_cnt, paused;
    model(dvd, dvs, w, s, f, eq, er);
    pq = quotient;
    pr = remainder;
    dividend = dvd; divisor = dvs; wide = w; signed_op = s; frac = f;
    start = 1'b1; step_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    check({tag, " R5 busy after start"}, 32'(busy), 32'd1);
    edges = 0; en_cnt = 0; paused = 0;
    while (!done && edges < 100) begin
      step_en = !(edges < 32 && pause_mask[edges]);
      if (edges == inject_at) begin
        start = 1'b1;
        dividend = dvd ^ 32'h0000_0155;
        divisor = dvs + 16'd3;
      end else begin
        start = 1'b0;
      end
      if (!done && en_cnt < 18) begin
        // R10: outputs keep the previous result while running
        if (quotient !== pq || remainder !== pr) begin
          total++; bad++;
          $display("FAIL %s R10 output moved early actual=%0h expected=%0h", tag, quotient, pq);
        end
      end
      @(posedge clk);
      if (step_en) en_cnt++; else paused++;
      @(negedge clk);
      edges++;
    end
    start = 1'b0;
    check({tag, " R5/R6 enabled steps to done"}, 32'(en_cnt), 32'd19);
    check({tag, " R6 total cycles"}, 32'(edges), 32'(19 + paused));
    check({tag, " R5 done seen"}, 32'(done), 32'd1);
    check({tag, " R8 div_zero"}, 32'(div_zero), 32'(dvs == 16'd0));
    if (dvs != 16'd0) begin
      check({tag, " quotient"}, 32'(quotient), 32'(eq));
      check({tag, " remainder"}, 32'(remainder), 32'(er));
    end
    step_en = 1'b0;
    pq = quotient; pr = remainder;
    @(posedge clk);
    @(negedge clk);
    check({tag, " R5 done one cycle"}, 32'(done), 32'd0);
    check({tag, " R5 idle after done"}, 32'(busy), 32'd0);
    check({tag, " R10 hold q"}, 32'(quotient), 32'(pq));
    check({tag, " R10 hold r"}, 32'(remainder), 32'(pr));
  endtask

  initial begin
    #(5.0 * 150000);
    bad++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R9 reset busy", 32'(busy), 32'd0);
    check("R9 reset done", 32'(done), 32'd0);
    check("R9 reset div_zero", 32'(div_zero), 32'd0);
    check("R9 reset quotient", 32'(quotient), 32'd0);
    check("R9 reset remainder", 32'(remainder), 32'd0);

    run_div("R1 100/7", 32'd100, 16'd7, 0, 0, 0, 32'd0, -1);
    run_div("R1 ffff/1", 32'h0000_FFFF, 16'd1, 0, 0, 0, 32'd0, -1);
    run_div("R1 upper ignored", 32'hABCD_1234, 16'h0100, 0, 0, 0, 32'd0, -1);
    run_div("R2 wide", 32'h0012_3456, 16'h1234, 1, 0, 0, 32'd0, -1);
    run_div("R2 wide max", 32'hFFFE_FFFF, 16'hFFFF, 1, 0, 0, 32'd0, -1);
    run_div("R3 -100/7", 32'h0000_FF9C, 16'd7, 0, 1, 0, 32'd0, -1);
    run_div("R3 100/-7", 32'd100, 16'hFFF9, 0, 1, 0, 32'd0, -1);
    run_div("R3 -100/-7", 32'h0000_FF9C, 16'hFFF9, 0, 1, 0, 32'd0, -1);
    run_div("R3 wide signed", 32'hFFF0_BDC0, 16'd1000, 1, 1, 0, 32'd0, -1);
    run_div("R4 frac 0.5/0.75", 32'h0000_4000, 16'h6000, 0, 0, 1, 32'd0, -1);
    run_div("R4 frac signed", 32'h0000_C000, 16'h6000, 1, 1, 1, 32'd0, -1);
    run_div("R4 frac neg divisor", 32'h0000_1234, 16'h8000, 0, 1, 1, 32'd0, -1);
    run_div("R6 paused first", 32'd50000, 16'd123, 0, 0, 0, 32'h0000_0003, -1);
    run_div("R6 paused mid", 32'h0000_8001, 16'h00FF, 0, 1, 0, 32'h0005_5A50, -1);
    run_div("R6 paused last", 32'h0007_0000, 16'h0009, 1, 0, 0, 32'h00C4_0000, -1);
    run_div("R7 restart ignored", 32'd9999, 16'd77, 0, 0, 0, 32'd0, 6);
    run_div("R7 restart paused", 32'd4321, 16'd10, 0, 0, 0, 32'h0000_0100, 8);
    run_div("R8 zero divisor", 32'd1234, 16'd0, 0, 0, 0, 32'd0, -1);
    run_div("R8 flag clears", 32'd1234, 16'd5, 0, 0, 0, 32'd0, -1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule